// File: doc/BRIEF.md
# Programmable Main Clock Divider

This block derives a system clock from the main oscillator clock. A five-bit ratio code selects one of ten divide ratios: pass-through, /2, /3, /4, /6, /8, /10, /12, /14 and /16. The encoding is sparse and irregular. Software loads the code through a simple write port. A write is accepted only while an external write-protect enable is high and the code is one of the ten legal values. The current code can always be read back.

A new ratio is not applied at once. It waits until the divided clock finishes its current period, so every output period belongs wholly to one ratio. When the oscillator is reported stopped, or the chip goes into stop mode, hardware forces the code back to the /8 default. This force wins over any write in the same cycle.

Top module: `mcd_div_top`

## Requirements
- R1: The ratio codes map as follows: 5'b10010 is pass-through (period of one input cycle), 5'b00010 is /2, 5'b00011 is /3, 5'b00100 is /4, 5'b00110 is /6, 5'b01000 is /8, 5'b01010 is /10, 5'b01100 is /12, 5'b01110 is /14 and 5'b00000 is /16. An accepted code reads back on rd_data_o[4:0] in the cycle after the write strobe.
- R2: For the even ratios the output is high for half the period. For /3 it is high for one input cycle and low for two. In pass-through the output follows the input clock.
- R3: After reset the code reads 5'b01000 and the output period is eight input cycles.
- R4: A write strobe while prot_en_i is 0 leaves the code and the output period unchanged.
- R5: A write of any code outside the ten legal values leaves the previous code and ratio in place.
- R6: While stop_mode_i or osc_stop_i is 1, the code becomes 5'b01000 on the next edge. This happens even if an accepted write arrives in the same cycle.
- R7: rd_data_o[7:5] always reads 0. wr_data_i[7:5] has no effect on the stored code.
- R8: A ratio change takes effect only when the current output period ends. Every complete output period has the length of either the old ratio or the new one.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe for the ratio register |
| wr_data_i | input | 8 | Write data; bits 4:0 hold the ratio code |
| prot_en_i | input | 1 | Write-protect enable; writes pass only when 1 |
| stop_mode_i | input | 1 | Chip is entering or in stop mode |
| osc_stop_i | input | 1 | Main oscillator reported stopped |
| rd_data_o | output | 8 | Read-back of the ratio register |
| clk_div_o | output | 1 | Divided system clock |

## Verification
The hardware fallback and a software write can land on the same edge. The bench raises stop_mode_i in the same cycle as a protected, legal write of the /2 code. It then requires the read-back to show 5'b01000 and the measured period to stay at eight cycles. The same collision is repeated with osc_stop_i. A separate check changes the ratio from /16 to /2 at an arbitrary phase. Each following period must then measure as 16 or 2 input cycles, and never anything in between.

// File: rtl/mcd_pkg.sv
`timescale 1ns/1ps
package mcd_pkg;
    localparam int CODE_W = 5;
    localparam int REG_W  = 8;
    localparam int CNT_W  = 5;

    localparam logic [CODE_W-1:0] CODE_DFLT = 5'b01000;

    typedef struct packed {
        logic             bypass;
        logic [CNT_W-1:0] ratio;
        logic [CNT_W-1:0] high;
    } div_cfg_t;

    function automatic logic code_legal(input logic [CODE_W-1:0] c);
        case (c)
            5'b10010, 5'b00010, 5'b00011, 5'b00100, 5'b00110,
            5'b01000, 5'b01010, 5'b01100, 5'b01110, 5'b00000: code_legal = 1'b1;
            default:                                           code_legal = 1'b0;
        endcase
    endfunction

    function automatic div_cfg_t code_cfg(input logic [CODE_W-1:0] c);
        div_cfg_t r;
        r.bypass = 1'b0;
        case (c)
            5'b10010: begin r.bypass = 1'b1; r.ratio = 5'd1; end
            5'b00010: r.ratio = 5'd2;
            5'b00011: r.ratio = 5'd3;
            5'b00100: r.ratio = 5'd4;
            5'b00110: r.ratio = 5'd6;
            5'b01010: r.ratio = 5'd10;
            5'b01100: r.ratio = 5'd12;
            5'b01110: r.ratio = 5'd14;
            5'b00000: r.ratio = 5'd16;
            default:  r.ratio = 5'd8;
        endcase
        if (r.ratio == 5'd3 || r.ratio == 5'd1) r.high = 5'd1;
        else                                     r.high = r.ratio >> 1;
        return r;
    endfunction
endpackage

// File: rtl/mcd_reg.sv
`timescale 1ns/1ps
module mcd_reg
    import mcd_pkg::*;
#(
    parameter logic [CODE_W-1:0] RST_CODE = CODE_DFLT
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [CODE_W-1:0] wr_code_i,
    input  logic              prot_en_i,
    input  logic              force_i,
    output logic [CODE_W-1:0] code_o
);
    typedef struct packed {
        logic [CODE_W-1:0] code;
    } reg_st_t;

    reg_st_t st_d, st_q;
    logic    wr_ok;

    always_comb begin
        st_d  = st_q;
        wr_ok = wr_en_i && prot_en_i && code_legal(wr_code_i);
        if (force_i)    st_d.code = RST_CODE;
        else if (wr_ok) st_d.code = wr_code_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q.code <= RST_CODE;
        else         st_q      <= st_d;
    end

    assign code_o = st_q.code;
endmodule

// File: rtl/mcd_gen.sv
`timescale 1ns/1ps
module mcd_gen
    import mcd_pkg::*;
#(
    parameter logic [CODE_W-1:0] RST_CODE = CODE_DFLT
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  div_cfg_t         cfg_i,
    output logic             phase_o,
    output logic             bypass_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] ratio_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        div_cfg_t         act;
        logic             phase;
    } gen_st_t;

    gen_st_t          st_d, st_q;
    logic             at_end;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        st_d    = st_q;
        at_end  = (st_q.cnt == st_q.act.ratio - 1'b1);
        cnt_inc = st_q.cnt + 1'b1;
        if (at_end) begin
            st_d.act   = cfg_i;
            st_d.cnt   = '0;
            st_d.phase = 1'b1;
        end else begin
            st_d.cnt   = cnt_inc;
            st_d.phase = (cnt_inc < st_q.act.high);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.cnt   <= '0;
            st_q.act   <= code_cfg(RST_CODE);
            st_q.phase <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o  = st_q.phase;
    assign bypass_o = st_q.act.bypass;
    assign cnt_o    = st_q.cnt;
    assign ratio_o  = st_q.act.ratio;
endmodule

// File: rtl/mcd_div_top.sv
`timescale 1ns/1ps
module mcd_div_top
    import mcd_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    input  logic             prot_en_i,
    input  logic             stop_mode_i,
    input  logic             osc_stop_i,
    output logic [REG_W-1:0] rd_data_o,
    output logic             clk_div_o
);
    logic [CODE_W-1:0] code_q;
    div_cfg_t          cfg_sel;
    logic              phase_q;
    logic              byp_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  act_ratio;
    logic              force_fb;
    logic              hi_bits_unused;

    assign force_fb       = stop_mode_i | osc_stop_i;
    assign hi_bits_unused = ^wr_data_i[REG_W-1:CODE_W];

    mcd_reg #(.RST_CODE(CODE_DFLT)) u_reg (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_code_i (wr_data_i[CODE_W-1:0]),
        .prot_en_i (prot_en_i),
        .force_i   (force_fb),
        .code_o    (code_q)
    );

    assign cfg_sel = code_cfg(code_q);

    mcd_gen #(.RST_CODE(CODE_DFLT)) u_gen (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .cfg_i    (cfg_sel),
        .phase_o  (phase_q),
        .bypass_o (byp_q),
        .cnt_o    (cnt_q),
        .ratio_o  (act_ratio)
    );

    assign rd_data_o = {{(REG_W-CODE_W){1'b0}}, code_q};
    assign clk_div_o = byp_q ? clk_i : phase_q;
endmodule

// File: rtl/mcd_div_chk.sv
`timescale 1ns/1ps
module mcd_div_chk
    import mcd_pkg::*;
(
    input logic             clk_i,
    input logic             rst_ni,
    input logic             prot_en_i,
    input logic             stop_mode_i,
    input logic             osc_stop_i,
    input logic [REG_W-1:0] rd_data_o,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] act_ratio
);
    p_force_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stop_mode_i || osc_stop_i) |=> (rd_data_o[CODE_W-1:0] == CODE_DFLT));

    p_prot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!prot_en_i && !stop_mode_i && !osc_stop_i) |=> $stable(rd_data_o));

    p_legal_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        code_legal(rd_data_o[CODE_W-1:0]));

    p_upper_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_data_o[REG_W-1:CODE_W] == '0);

    p_boundary_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_q != act_ratio - 1'b1) |=> $stable(act_ratio));

    p_cnt_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q < act_ratio);
endmodule

bind mcd_div_top mcd_div_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .prot_en_i   (prot_en_i),
    .stop_mode_i (stop_mode_i),
    .osc_stop_i  (osc_stop_i),
    .rd_data_o   (rd_data_o),
    .cnt_q       (cnt_q),
    .act_ratio   (act_ratio)
);

// File: tb/sim_mcd_div_top.sv
`timescale 1ns/1ps
module sim_mcd_div_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       prot_en = 1'b0;
    logic       stop_mode = 1'b0;
    logic       osc_stop = 1'b0;
    logic [7:0] rd_data;
    logic       clk_div;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mcd_div_top u0 (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
        .prot_en_i(prot_en), .stop_mode_i(stop_mode), .osc_stop_i(osc_stop),
        .rd_data_o(rd_data), .clk_div_o(clk_div)
    );

    // {code, ratio, high time in half input cycles}
    localparam logic [14:0] VEC [10] = '{
        {5'b10010, 5'd1,  5'd1},  {5'b00010, 5'd2,  5'd2},
        {5'b00011, 5'd3,  5'd2},  {5'b00100, 5'd4,  5'd4},
        {5'b00110, 5'd6,  5'd6},  {5'b01000, 5'd8,  5'd8},
        {5'b01010, 5'd10, 5'd10}, {5'b01100, 5'd12, 5'd12},
        {5'b01110, 5'd14, 5'd14}, {5'b00000, 5'd16, 5'd16}
    };

    task automatic check(input bit ok, input string req, input real act, input real exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0.2f expected=%0.2f", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d, input bit prot, input bit stp, input bit osc);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; prot_en = prot; stop_mode = stp; osc_stop = osc;
        @(negedge clk);
        wr_en = 1'b0; prot_en = 1'b0; stop_mode = 1'b0; osc_stop = 1'b0;
    endtask

    task automatic settle();
        repeat (40) @(negedge clk);
    endtask

    task automatic measure(output real per, output real hi);
        real t0, t1, t2;
        @(posedge clk_div); t0 = $realtime;
        @(negedge clk_div); t1 = $realtime;
        @(posedge clk_div); t2 = $realtime;
        per = t2 - t0; hi = t1 - t0;
    endtask

    function automatic bit near(input real a, input real b);
        return (a - b < 0.01) && (b - a < 0.01);
    endfunction

    initial begin
        real per, hi, tp, tn;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R3: reset code and period
        check(rd_data == 8'h08, "R3 reset code", real'(rd_data), 8.0);
        measure(per, hi);
        check(near(per, 32.0), "R3 reset period", per, 32.0);

        // R1/R2: all legal codes
        for (int i = 0; i < 10; i++) begin
            wr({3'b000, VEC[i][14:10]}, 1'b1, 1'b0, 1'b0);
            check(rd_data == {3'b000, VEC[i][14:10]}, "R1 readback",
                  real'(rd_data), real'(VEC[i][14:10]));
            settle();
            measure(per, hi);
            check(near(per, 4.0 * VEC[i][9:5]), "R1 period", per, 4.0 * VEC[i][9:5]);
            check(near(hi, 2.0 * VEC[i][4:0]), "R2 high time", hi, 2.0 * VEC[i][4:0]);
        end

        // R4: protected write ignored (now at /16)
        wr(8'h04, 1'b0, 1'b0, 1'b0);
        check(rd_data == 8'h00, "R4 code kept", real'(rd_data), 0.0);
        settle(); measure(per, hi);
        check(near(per, 64.0), "R4 period kept", per, 64.0);

        // R5: illegal codes ignored
        wr(8'h01, 1'b1, 1'b0, 1'b0);
        check(rd_data == 8'h00, "R5 illegal 00001", real'(rd_data), 0.0);
        wr(8'h13, 1'b1, 1'b0, 1'b0);
        check(rd_data == 8'h00, "R5 illegal 10011", real'(rd_data), 0.0);
        settle(); measure(per, hi);
        check(near(per, 64.0), "R5 period kept", per, 64.0);

        // R7: upper write bits dropped, upper read bits zero
        wr(8'hE4, 1'b1, 1'b0, 1'b0);
        check(rd_data == 8'h04, "R7 upper bits", real'(rd_data), 4.0);
        settle(); measure(per, hi);
        check(near(per, 16.0), "R7 period /4", per, 16.0);

        // R6: stop mode alone, then collision with write
        wr(8'h00, 1'b0, 1'b1, 1'b0);
        check(rd_data == 8'h08, "R6 stop fallback", real'(rd_data), 8.0);
        wr(8'h02, 1'b1, 1'b0, 1'b0);
        wr(8'h02, 1'b1, 1'b1, 1'b0);
        check(rd_data == 8'h08, "R6 stop beats write", real'(rd_data), 8.0);
        settle(); measure(per, hi);
        check(near(per, 32.0), "R6 period after stop", per, 32.0);
        wr(8'h0E, 1'b1, 1'b0, 1'b0);
        wr(8'h02, 1'b1, 1'b0, 1'b1);
        check(rd_data == 8'h08, "R6 osc stop beats write", real'(rd_data), 8.0);
        settle(); measure(per, hi);
        check(near(per, 32.0), "R6 period after osc stop", per, 32.0);

        // R8: /16 to /2 at an arbitrary phase
        wr(8'h00, 1'b1, 1'b0, 1'b0);
        settle();
        @(posedge clk_div);
        repeat (5) @(negedge clk);
        wr(8'h02, 1'b1, 1'b0, 1'b0);
        @(posedge clk_div); tp = $realtime;
        for (int k = 0; k < 4; k++) begin
            @(posedge clk_div); tn = $realtime;
            per = tn - tp; tp = tn;
            check(near(per, 64.0) || near(per, 8.0), "R8 whole period", per, 8.0);
        end
        check(near(per, 8.0), "R8 new ratio applied", per, 8.0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule